// File: doc/BRIEF.md
# Trellis state-metric buffer controller

This block sequences the state-metric storage of a serial trellis decoder that updates one state per clock. Each trellis step is one sweep over all `NUM_STATES` states followed by a fixed run of `OVERHEAD` idle cycles. During a sweep the controller reads the current metrics from one bank of a two-bank working RAM. It writes the new metrics, produced by external add-compare-select logic, into the other bank. The banks swap roles on every step.

Each metric that returns from the working-RAM read port is passed to the datapath and is also copied into a delay RAM, which feeds the reverse recursion. Because the copy is taken from the read port, the delay RAM is written and later read in one shared address order, so a single wrapping address is enough. Two substitutions produce the initial conditions. On the first step of a block, the metric presented to the datapath is forced to the initial set. On the last step of a block, the metric written to the delay RAM is forced to the same set, so that the reverse pass starts from a known tail.

A block spans `BLOCK_STEPS` steps, which is twice the code block length. The block-start strobe is honoured when the controller is idle, or on the final cycle of a block, where it chains straight into a new block. At any other time it is ignored.

Top module: `smb_ctrl`

## Requirements
- R1: While rst_ni is low, busy_o, wk_rd_en_o, wk_wr_en_o, dly_we_o and step_done_o are 0 and dly_addr_o is 0.
- R2: start_i sampled high while idle begins step 0 on the next cycle. During a step, wk_rd_en_o is high for NUM_STATES consecutive cycles, with wk_rd_addr_o = {step parity, state index} and the state index counting 0 upward by one per cycle. The bank bit is the MSB.
- R3: A step lasts NUM_STATES + OVERHEAD cycles. No working-RAM read occurs in the last OVERHEAD cycles, and step_done_o is high on exactly the last of them.
- R4: Exactly one cycle after each working-RAM read, wk_wr_en_o is high. wk_wr_addr_o carries the same state index with the opposite bank bit, and wk_wr_data_o equals acs_data_i. No write occurs at any other time.
- R5: When a read's data returns (one cycle after the read), sm_o equals wk_rd_data_i. The exception is step 0 of a block, where sm_o is forced to 0 for state 0 and to the all-ones value (255 for 8 bits) for every other state.
- R6: dly_we_o is high exactly when read data returns. dly_wdata_o equals wk_rd_data_i, except in the last step of a block, where it is forced to the initial values of R5.
- R7: dly_addr_o starts at 0, advances by one after each delay write, wraps from DLY_DEPTH-1 to 0, and otherwise holds.
- R8: A block is BLOCK_STEPS steps long. If start_i is low on the block's final cycle, busy_o falls on the next cycle. If start_i is high on that cycle, step 0 of a new block begins on the next cycle with no gap.
- R9: start_i high on any cycle of a running block other than its final cycle has no effect on the sequence of addresses, enables or busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Block-start strobe |
| wk_rd_data_i | input | SM_W | Working-RAM read data, valid one cycle after the read |
| acs_data_i | input | SM_W | New metric from the add-compare-select logic, aligned with returned read data |
| wk_rd_en_o | output | 1 | Working-RAM read enable |
| wk_rd_addr_o | output | log2(NUM_STATES)+1 | Working-RAM read address: {bank, state} |
| wk_wr_en_o | output | 1 | Working-RAM write enable |
| wk_wr_addr_o | output | log2(NUM_STATES)+1 | Working-RAM write address: {bank, state} |
| wk_wr_data_o | output | SM_W | Working-RAM write data |
| sm_o | output | SM_W | Metric presented to the datapath |
| dly_we_o | output | 1 | Delay-RAM write enable |
| dly_addr_o | output | log2(DLY_DEPTH) | Shared delay-RAM address for write and read |
| dly_wdata_o | output | SM_W | Delay-RAM write data |
| step_done_o | output | 1 | Last cycle of a trellis step |
| busy_o | output | 1 | A block is in progress |

## Verification
The assertions assume that start_i is synchronous to clk_i, that the working RAM returns read data exactly one cycle after the read, that NUM_STATES is a power of two and that BLOCK_STEPS is at least 2. The stimulus drives start_i and both data inputs just after the falling edge. The data inputs take fresh random values every cycle. Random start pulses appear only inside running blocks, so the mid-block strobes exercise R9. Exactly one block boundary receives a chaining strobe, and the other boundaries let the controller return to idle before a new start is given.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/smb_seq.sv
module smb_seq
  import smb_pkg::*;
#(
  parameter int unsigned NUM_STATES  = 512,
  parameter int unsigned OVERHEAD    = 13,
  parameter int unsigned BLOCK_STEPS = 256,
  localparam int unsigned STEP_LEN   = NUM_STATES + OVERHEAD,
  localparam int unsigned PH_W       = $clog2(STEP_LEN),
  localparam int unsigned ST_W       = $clog2(BLOCK_STEPS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic            run_o,
  output logic [PH_W-1:0] phase_o,
  output logic [ST_W-1:0] step_o,
  output logic            rd_en_o,
  output logic            first_step_o,
  output logic            last_step_o,
  output logic            step_done_o
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(STEP_LEN - 1);
  localparam logic [PH_W-1:0] RD_END  = PH_W'(NUM_STATES);
  localparam logic [ST_W-1:0] LAST_ST = ST_W'(BLOCK_STEPS - 1);

  seq_state_e      state_q;
  logic [PH_W-1:0] phase_q;
  logic [ST_W-1:0] step_q;
  logic            at_step_end, at_block_end;

  assign at_step_end  = (state_q == SEQ_RUN) && (phase_q == LAST_PH);
  assign at_block_end = at_step_end && (step_q == LAST_ST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      phase_q <= '0;
      step_q  <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            state_q <= SEQ_RUN;
            phase_q <= '0;
            step_q  <= '0;
          end
        end
        default: begin
          if (at_block_end) begin
            // chaining strobe only honoured here
            phase_q <= '0;
            step_q  <= '0;
            if (!start_i) state_q <= SEQ_IDLE;
          end else if (at_step_end) begin
            phase_q <= '0;
            step_q  <= step_q + ST_W'(1);
          end else begin
            phase_q <= phase_q + PH_W'(1);
          end
        end
      endcase
    end
  end

  assign run_o        = (state_q == SEQ_RUN);
  assign phase_o      = phase_q;
  assign step_o       = step_q;
  assign rd_en_o      = run_o && (phase_q < RD_END);
  assign first_step_o = (step_q == '0);
  assign last_step_o  = (step_q == LAST_ST);
  assign step_done_o  = at_step_end;

  AST_BLOCK_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_done_o && last_step_o && !start_i) |=> !run_o); // R8
  AST_BLOCK_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_done_o && last_step_o && start_i) |=> (run_o && step_o == '0 && phase_o == '0)); // R8
  AST_MID_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !(step_done_o && last_step_o) && start_i) |=> (run_o && (phase_o != '0 || step_o != '0))); // R9
endmodule

// File: rtl/smb_rdpipe.sv
module smb_rdpipe #(
  parameter int unsigned SA_W = 9,
  parameter int unsigned SM_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_en_i,
  input  logic [SA_W-1:0] rd_idx_i,
  input  logic            rd_bank_i,
  input  logic            first_i,
  input  logic            last_i,
  input  logic [SM_W-1:0] wk_rd_data_i,
  input  logic [SM_W-1:0] acs_data_i,
  output logic            wr_en_o,
  output logic [SA_W:0]   wr_addr_o,
  output logic [SM_W-1:0] wr_data_o,
  output logic [SM_W-1:0] sm_o,
  output logic            dly_we_o,
  output logic [SM_W-1:0] dly_wdata_o
);
  logic            vld_q, bank_q, first_q, last_q;
  logic [SA_W-1:0] idx_q;
  logic [SM_W-1:0] init_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      bank_q  <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      vld_q <= rd_en_i;
      if (rd_en_i) begin
        bank_q  <= rd_bank_i;
        first_q <= first_i;
        last_q  <= last_i;
        idx_q   <= rd_idx_i;
      end
    end
  end

  // state 0 best, all others worst
  assign init_val    = (idx_q == '0) ? '0 : '1;
  assign wr_en_o     = vld_q;
  assign wr_addr_o   = {~bank_q, idx_q};
  assign wr_data_o   = acs_data_i;
  assign sm_o        = first_q ? init_val : wk_rd_data_i;
  assign dly_we_o    = vld_q;
  assign dly_wdata_o = last_q ? init_val : wk_rd_data_i;
endmodule

// File: rtl/smb_dly_addr.sv
module smb_dly_addr #(
  parameter int unsigned DEPTH = 4096,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   addr_q <= '0;
    else if (we_i) addr_q <= (addr_q == LAST) ? '0 : addr_q + AW'(1);
  end

  assign addr_o = addr_q;

  AST_DLY_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_o == LAST) |=> (addr_o == '0)); // R7
  AST_DLY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(addr_o)); // R7
endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl #(
  parameter int unsigned NUM_STATES  = 512,
  parameter int unsigned OVERHEAD    = 13,
  parameter int unsigned BLOCK_STEPS = 256,
  parameter int unsigned DLY_DEPTH   = 4096,
  parameter int unsigned SM_W        = 8,
  localparam int unsigned SA_W       = $clog2(NUM_STATES),
  localparam int unsigned DLY_AW     = $clog2(DLY_DEPTH),
  localparam int unsigned PH_W       = $clog2(NUM_STATES + OVERHEAD),
  localparam int unsigned ST_W       = $clog2(BLOCK_STEPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SM_W-1:0]   wk_rd_data_i,
  input  logic [SM_W-1:0]   acs_data_i,
  output logic              wk_rd_en_o,
  output logic [SA_W:0]     wk_rd_addr_o,
  output logic              wk_wr_en_o,
  output logic [SA_W:0]     wk_wr_addr_o,
  output logic [SM_W-1:0]   wk_wr_data_o,
  output logic [SM_W-1:0]   sm_o,
  output logic              dly_we_o,
  output logic [DLY_AW-1:0] dly_addr_o,
  output logic [SM_W-1:0]   dly_wdata_o,
  output logic              step_done_o,
  output logic              busy_o
);
  logic            run, rd_en, first_step, last_step;
  logic [PH_W-1:0] phase;
  logic [ST_W-1:0] step;
  logic            dly_we;

  smb_seq #(
    .NUM_STATES (NUM_STATES),
    .OVERHEAD   (OVERHEAD),
    .BLOCK_STEPS(BLOCK_STEPS)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .run_o       (run),
    .phase_o     (phase),
    .step_o      (step),
    .rd_en_o     (rd_en),
    .first_step_o(first_step),
    .last_step_o (last_step),
    .step_done_o (step_done_o)
  );

  // bank alternates with step parity
  assign wk_rd_en_o   = rd_en;
  assign wk_rd_addr_o = {step[0], phase[SA_W-1:0]};
  assign busy_o       = run;

  smb_rdpipe #(
    .SA_W(SA_W),
    .SM_W(SM_W)
  ) u_rdpipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_en_i     (rd_en),
    .rd_idx_i    (phase[SA_W-1:0]),
    .rd_bank_i   (step[0]),
    .first_i     (first_step),
    .last_i      (last_step),
    .wk_rd_data_i(wk_rd_data_i),
    .acs_data_i  (acs_data_i),
    .wr_en_o     (wk_wr_en_o),
    .wr_addr_o   (wk_wr_addr_o),
    .wr_data_o   (wk_wr_data_o),
    .sm_o        (sm_o),
    .dly_we_o    (dly_we),
    .dly_wdata_o (dly_wdata_o)
  );

  assign dly_we_o = dly_we;

  smb_dly_addr #(
    .DEPTH(DLY_DEPTH)
  ) u_dly_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (dly_we),
    .addr_o(dly_addr_o)
  );

  AST_BANKS_DISJOINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wk_rd_en_o && wk_wr_en_o) |-> (wk_rd_addr_o[SA_W] != wk_wr_addr_o[SA_W])); // R4
  AST_WR_TRACKS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wk_wr_en_o |-> ($past(wk_rd_en_o) && wk_wr_addr_o[SA_W-1:0] == $past(wk_rd_addr_o[SA_W-1:0]))); // R4
  AST_QUIET_AFTER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_done_o |=> !wk_wr_en_o); // R3
  AST_DLY_WITH_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dly_we_o |-> wk_wr_en_o); // R6
endmodule

// File: tb/smb_ctrl_tb.sv
module smb_ctrl_tb_top;
  localparam int NS   = 8;
  localparam int OV   = 13;
  localparam int BS   = 4;
  localparam int DD   = 12;
  localparam int SW   = 8;
  localparam int SA   = 3;
  localparam int DAW  = 4;
  localparam int LAST = NS + OV - 1;
  localparam int BL   = BS * (NS + OV);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [SW-1:0] rd_data = '0;
  logic [SW-1:0] acs = '0;

  logic          wk_rd_en_o, wk_wr_en_o, dly_we_o, step_done_o, busy_o;
  logic [SA:0]   wk_rd_addr_o, wk_wr_addr_o;
  logic [SW-1:0] wk_wr_data_o, sm_o, dly_wdata_o;
  logic [DAW-1:0] dly_addr_o;

  always #10 clk = ~clk;

  smb_ctrl #(
    .NUM_STATES (NS),
    .OVERHEAD   (OV),
    .BLOCK_STEPS(BS),
    .DLY_DEPTH  (DD),
    .SM_W       (SW)
  ) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .wk_rd_data_i(rd_data),
    .acs_data_i  (acs),
    .wk_rd_en_o  (wk_rd_en_o),
    .wk_rd_addr_o(wk_rd_addr_o),
    .wk_wr_en_o  (wk_wr_en_o),
    .wk_wr_addr_o(wk_wr_addr_o),
    .wk_wr_data_o(wk_wr_data_o),
    .sm_o        (sm_o),
    .dly_we_o    (dly_we_o),
    .dly_addr_o  (dly_addr_o),
    .dly_wdata_o (dly_wdata_o),
    .step_done_o (step_done_o),
    .busy_o      (busy_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int restarts_left = 0;

  // reference model state
  int m_act, m_step, m_ph, m_vld, m_idx, m_bank, m_first, m_last, m_dly;

  function automatic int init_m(int idx);
    return (idx == 0) ? 0 : 255;
  endfunction

  task automatic chk_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_ni) begin : model
    if (!rst_ni) begin
      m_act = 0; m_step = 0; m_ph = 0; m_vld = 0;
      m_idx = 0; m_bank = 0; m_first = 0; m_last = 0; m_dly = 0;
    end else begin
      if (m_vld != 0) m_dly = (m_dly + 1) % DD;
      m_vld = (m_act != 0 && m_ph < NS) ? 1 : 0;
      if (m_vld != 0) begin
        m_idx   = m_ph;
        m_bank  = m_step % 2;
        m_first = (m_step == 0) ? 1 : 0;
        m_last  = (m_step == BS - 1) ? 1 : 0;
      end
      if (m_act == 0) begin
        if (start_i) begin m_act = 1; m_ph = 0; m_step = 0; end
      end else if (m_ph == LAST) begin
        m_ph = 0;
        if (m_step == BS - 1) begin
          m_step = 0;
          if (!start_i) m_act = 0;
        end else m_step++;
      end else m_ph++;
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      int exp_rd;
      exp_rd = (m_act != 0 && m_ph < NS) ? 1 : 0;
      chk_eq("R2 rd_en", int'(wk_rd_en_o), exp_rd);
      if (exp_rd != 0) chk_eq("R2 rd_addr", int'(wk_rd_addr_o), (m_step % 2) * NS + m_ph);
      chk_eq("R3 step_done", int'(step_done_o), (m_act != 0 && m_ph == LAST) ? 1 : 0);
      chk_eq("R4 wr_en", int'(wk_wr_en_o), m_vld);
      chk_eq("R6 dly_we", int'(dly_we_o), m_vld);
      chk_eq("R7 dly_addr", int'(dly_addr_o), m_dly);
      chk_eq("R8 R9 busy", int'(busy_o), m_act);
      if (m_vld != 0) begin
        chk_eq("R4 wr_addr", int'(wk_wr_addr_o), (1 - m_bank) * NS + m_idx);
        chk_eq("R4 wr_data", int'(wk_wr_data_o), int'(acs));
        chk_eq("R5 sm", int'(sm_o), (m_first != 0) ? init_m(m_idx) : int'(rd_data));
        chk_eq("R6 dly_wdata", int'(dly_wdata_o), (m_last != 0) ? init_m(m_idx) : int'(rd_data));
      end
    end
  end

  task automatic drive(int n, bit kick, bit noise);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      rd_data = SW'($urandom);
      acs     = SW'($urandom);
      if (m_act != 0 && m_step == BS - 1 && m_ph == LAST) begin
        start_i = (restarts_left > 0);
        if (restarts_left > 0) restarts_left--;
      end else if (m_act == 0) begin
        start_i = kick;
      end else begin
        start_i = noise && ($urandom_range(3) == 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk_eq("R1 busy", int'(busy_o), 0);
    chk_eq("R1 rd_en", int'(wk_rd_en_o), 0);
    chk_eq("R1 wr_en", int'(wk_wr_en_o), 0);
    chk_eq("R1 dly_we", int'(dly_we_o), 0);
    chk_eq("R1 step_done", int'(step_done_o), 0);
    chk_eq("R1 dly_addr", int'(dly_addr_o), 0);
    rst_ni = 1'b1;
    drive(6, 1'b0, 1'b0);          // idle, no start
    drive(1, 1'b1, 1'b0);          // R2 start from idle
    restarts_left = 1;             // R8 one chained block, R9 noise
    drive(2 * BL + 12, 1'b0, 1'b1);
    drive(1, 1'b1, 1'b0);          // R2 fresh start after idle
    drive(BL + DD, 1'b0, 1'b0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      done = 1;
      $display("FAIL R8 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule